// File: doc/BRIEF.md
# PS/2 Port Register Block

This block is the processor-facing register front end of one PS/2 keyboard or mouse port. A word-addressed bus with byte offsets, separate read and write strobes and 32-bit data reaches a control word, a status word, a data register, a clock divisor store, an interrupt status word and a read-only identification window at the top of a 4 KB region. Behind it sits a serial engine that handles the wire protocol. The engine offers received bytes through a valid/byte/pop interface and takes bytes to send through a byte/strobe interface.

A read of the data register takes the waiting byte, if there is one, and keeps it as the last byte. The receive parity shown in the status word is computed from that kept byte. The single interrupt output combines a receive interrupt enable with the pending receive byte, and a second control bit forces the interrupt high on its own.

Top module: `ps2_regfile`

## Requirements
- R1: After reset the control word, the clock divisor, the kept last byte and the read data output are all zero, and `irq` is low while `rx_valid` is low.
- R2: A write to offset 0x000 stores all 32 bits of control, and a read of offset 0x000 returns them.
- R3: A write to offset 0x00C stores all 32 bits of the clock divisor, and a read of offset 0x00C returns them.
- R4: A read of offset 0x004 returns bit 6 = 1, bit 4 = `rx_valid`, and bit 2 = XOR of the eight bits of the kept last byte. All other bits are 0.
- R5: A read of offset 0x008 while `rx_valid` is high pulses `rx_pop` in that same cycle, stores `rx_byte` as the kept last byte and returns it. With `rx_valid` low the read does not pop and returns the previous kept byte.
- R6: `irq` equals (control bit 4 AND `rx_valid`) OR control bit 3, following a control write from the cycle after the write.
- R7: A read of offset 0x010 returns bit 1 = 1, bit 0 = `rx_valid`, and all other bits 0.
- R8: A write to offset 0x008 pulses `tx_strobe` in the write cycle with `tx_byte` equal to write data bits 7:0. No other access pulses `tx_strobe`.
- R9: Reads of byte offsets 0xFE0 to 0xFFC return one identification byte per word, zero-extended, in the order 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Reads of any other offset return 0. Writes to any offset other than 0x000, 0x008 and 0x00C change no stored state.
- R11: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset within the 4 KB window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | Serial engine holds a received byte |
| rx_byte | input | 8 | Received byte offered by the engine |
| rx_pop | output | 1 | Consume the offered byte |
| tx_byte | output | 8 | Byte to send |
| tx_strobe | output | 1 | Send request for `tx_byte` |
| irq | output | 1 | Combined interrupt |

## Verification
The received-byte path is driven with bytes of even and odd parity (0x00, 0x01, 0xFF, 0x7F, 0xA5, 0x3C). A parity bit taken from the offered byte instead of the kept one therefore shows up in the status word. Reads of data with an empty engine queue and back-to-back reads with several bytes queued separate a missing pop from a double pop. Control values that set only the enable, only the force bit, both or neither separate the two interrupt terms. Writes and reads to unmapped offsets, to the read-only words and to just below the identification window show whether stored state leaks or decoding overlaps.

// File: rtl/ps2_regfile.sv
module ps2_regfile #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  output logic          rx_pop,
  output logic [7:0]    tx_byte,
  output logic          tx_strobe,
  output logic          irq
);
  localparam int IW = AW - 2;
  localparam logic [IW-1:0] IX_CTRL = IW'(0);
  localparam logic [IW-1:0] IX_STAT = IW'(1);
  localparam logic [IW-1:0] IX_DATA = IW'(2);
  localparam logic [IW-1:0] IX_DIV  = IW'(3);
  localparam logic [IW-1:0] IX_INT  = IW'(4);
  localparam logic [IW-1:0] IX_ID   = IW'((1 << IW) - 8);

  logic [DW-1:0] ctrl_q, div_q, rdata_q, rd_mux;
  logic [7:0]    last_q, last_d;
  logic [IW-1:0] idx;
  logic          in_id;

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0: id_byte = 8'h50;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  assign idx       = bus_addr[AW-1:2];
  assign in_id     = idx >= IX_ID;
  assign rx_pop    = bus_rd & (idx == IX_DATA) & rx_valid;
  assign tx_strobe = bus_wr & (idx == IX_DATA);
  assign tx_byte   = bus_wdata[7:0];
  assign irq       = (ctrl_q[4] & rx_valid) | ctrl_q[3];
  assign last_d    = rx_pop ? rx_byte : last_q;
  assign bus_rdata = rdata_q;

  always_comb begin
    rd_mux = '0;
    if (in_id) begin
      rd_mux[7:0] = id_byte(idx[2:0]);
    end else begin
      case (idx)
        IX_CTRL: rd_mux = ctrl_q;
        IX_STAT: begin
          rd_mux[6] = 1'b1;
          rd_mux[4] = rx_valid;
          rd_mux[2] = ^last_q;
        end
        IX_DATA: rd_mux[7:0] = last_d;
        IX_DIV:  rd_mux = div_q;
        IX_INT: begin
          rd_mux[1] = 1'b1;
          rd_mux[0] = rx_valid;
        end
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      div_q   <= '0;
      last_q  <= '0;
      rdata_q <= '0;
    end else begin
      last_q <= last_d;
      if (bus_wr && idx == IX_CTRL) ctrl_q <= bus_wdata;
      if (bus_wr && idx == IX_DIV)  div_q  <= bus_wdata;
      if (bus_rd) rdata_q <= rd_mux;
    end
  end
endmodule

module ps2_regfile_sva (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] bus_addr,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        rx_valid,
  input logic        rx_pop,
  input logic [7:0]  tx_byte,
  input logic        tx_strobe,
  input logic        irq
);
  AST_POP_ONLY_ON_DATA_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> (bus_rd && bus_addr[11:2] == 10'd2 && rx_valid)); // R5
  AST_TX_ONLY_ON_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> (bus_wr && bus_addr[11:2] == 10'd2)); // R8
  AST_IRQ_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[11:2] == 10'd0 && bus_wdata[3]) |=> irq); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[11:2] == 10'd0 && bus_wdata[4:3] == 2'b00) |=> !irq); // R6
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R11
  AST_INT_STATUS_TX_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[11:2] == 10'd4) |=> (bus_rdata[31:1] == 31'd1)); // R7
  AST_ID_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[11:2] == 10'h3F8) |=> (bus_rdata == 32'h50)); // R9
endmodule

bind ps2_regfile ps2_regfile_sva u_sva (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_pop(rx_pop),
  .tx_byte(tx_byte), .tx_strobe(tx_strobe), .irq(irq)
);

// File: tb/ps2_regfile_tb.sv
module ps2_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_pop, tx_strobe, irq;
  logic [7:0]  tx_byte;

  int checks = 0, errors = 0;
  bit started = 1'b0, done = 1'b0;

  logic [7:0]  q[$];
  logic [31:0] m_cr = '0, m_div = '0, m_rd = '0;
  logic [7:0]  m_last = '0;
  string       m_tag = "R1";

  always #10 clk = ~clk;

  ps2_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_pop(rx_pop), .tx_byte(tx_byte), .tx_strobe(tx_strobe), .irq(irq)
  );

  function automatic logic [7:0] id_ref(input int k);
    logic [7:0] t[8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[k];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int w;
    started = 1'b1;
    w = int'(addr[11:2]);
    if (!rst_n) begin
      m_cr = '0; m_div = '0; m_rd = '0; m_last = '0; m_tag = "R1";
    end else begin
      if (wr && w == 0) m_cr = wdata;
      if (wr && w == 3) m_div = wdata;
      if (rd) begin
        if (w >= 'h3F8) begin m_rd = {24'b0, id_ref(w - 'h3F8)}; m_tag = "R9"; end
        else if (w == 0) begin m_rd = m_cr; m_tag = "R2"; end
        else if (w == 1) begin
          m_rd = 32'h40 | (rx_valid ? 32'h10 : 32'h0) | ((^m_last) ? 32'h4 : 32'h0);
          m_tag = "R4";
        end else if (w == 2) begin
          if (rx_valid) m_last = q.pop_front();
          m_rd = {24'b0, m_last}; m_tag = "R5";
        end else if (w == 3) begin m_rd = m_div; m_tag = "R3"; end
        else if (w == 4) begin m_rd = {30'b0, 1'b1, rx_valid}; m_tag = "R7"; end
        else begin m_rd = '0; m_tag = "R10"; end
      end else m_tag = "R11";
    end
    #2;
    rx_valid = q.size() != 0;
    rx_byte = rx_valid ? q[0] : 8'h00;
  end

  always @(negedge clk) if (started && !done) begin
    chk(bus_rdata == m_rd, m_tag, bus_rdata, m_rd);
    chk(irq == ((m_cr[4] & rx_valid) | m_cr[3]), "R6 irq", 32'(irq), 32'((m_cr[4] & rx_valid) | m_cr[3]));
    chk(rx_pop == (rd && addr[11:2] == 10'd2 && rx_valid), "R5 pop", 32'(rx_pop),
        32'(rd && addr[11:2] == 10'd2 && rx_valid));
    chk(tx_strobe == (wr && addr[11:2] == 10'd2), "R8 strobe", 32'(tx_strobe), 32'(wr && addr[11:2] == 10'd2));
    if (tx_strobe) chk(tx_byte == wdata[7:0], "R8 byte", 32'(tx_byte), 32'(wdata[7:0]));
  end

  task automatic cyc(input bit r, input bit w, input logic [11:0] a, input logic [31:0] d);
    #1; rd = r; wr = w; addr = a; wdata = d;
    @(posedge clk);
  endtask
  task automatic rd_at(input logic [11:0] a); cyc(1'b1, 1'b0, a, 32'h0); endtask
  task automatic wr_at(input logic [11:0] a, input logic [31:0] d); cyc(1'b0, 1'b1, a, d); endtask
  task automatic idle(); cyc(1'b0, 1'b0, 12'h0, 32'h0); endtask
  task automatic push(input logic [7:0] b);
    #1; rd = 1'b0; wr = 1'b0; q.push_back(b);
    @(posedge clk);
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
    idle();
    // R1 reset values read back
    rd_at(12'h000); rd_at(12'h00C); rd_at(12'h004); rd_at(12'h008);
    // R2 R3 full-width storage, R11 low address bits ignored
    wr_at(12'h000, 32'hA5A5_0003); rd_at(12'h000); idle(); idle();
    wr_at(12'h00C, 32'hDEAD_BEEF); rd_at(12'h00F); rd_at(12'h00D);
    // R6 interrupt term combinations
    wr_at(12'h000, 32'h0000_0010); idle();
    push(8'h01); idle(); rd_at(12'h004); rd_at(12'h010); rd_at(12'h008); idle();
    rd_at(12'h004); rd_at(12'h010);
    wr_at(12'h000, 32'h0000_0008); idle();
    wr_at(12'h000, 32'h0000_0018); push(8'hFF); idle();
    wr_at(12'h000, 32'h0000_0000); idle();
    rd_at(12'h004); rd_at(12'h008); rd_at(12'h004);
    // R5 empty read keeps the previous byte
    rd_at(12'h008); rd_at(12'h008);
    // R5 back-to-back pops of a queue
    push(8'h7F); push(8'hA5); push(8'h3C); push(8'h00);
    wr_at(12'h000, 32'h0000_0010);
    rd_at(12'h004); rd_at(12'h008); rd_at(12'h004); rd_at(12'h008); rd_at(12'h008);
    rd_at(12'h004); rd_at(12'h008); rd_at(12'h004); rd_at(12'h008); rd_at(12'h010);
    // R8 transmit writes
    wr_at(12'h008, 32'h1234_56F4); wr_at(12'h008, 32'h0000_00ED); idle();
    // R9 identification window
    for (int k = 0; k < 8; k++) rd_at(12'hFE0 + 12'(k * 4));
    rd_at(12'hFFE);
    // R10 unmapped offsets and read-only words
    wr_at(12'h004, 32'hFFFF_FFFF); wr_at(12'h010, 32'hFFFF_FFFF);
    wr_at(12'h014, 32'hFFFF_FFFF); wr_at(12'hFE0, 32'hFFFF_FFFF); wr_at(12'h800, 32'h1);
    rd_at(12'h000); rd_at(12'h00C); rd_at(12'h014); rd_at(12'h800); rd_at(12'hFDC);
    rd_at(12'hFE0); rd_at(12'h004);
    push(8'h55); rd_at(12'h014); rd_at(12'h004);
    wr_at(12'h000, 32'hFFFF_FFFF); rd_at(12'h000); idle();
    // R1 reset again with a byte waiting
    #1 rst_n = 1'b0;
    @(posedge clk); @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
    rd_at(12'h000); rd_at(12'h004); rd_at(12'h008); idle(); idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule